// File: doc/BRIEF.md
# Iterative Queue-to-Uplink Round-Robin Matcher

This block makes the first-stage pairing inside one ingress module of a three-stage switch fabric. The module holds one virtual output queue per fabric output. That gives `NUM_VOQ` queues, and the module has `NUM_LINK` uplinks toward the centre stage. At the start of a matching round the block takes a snapshot of the queue occupancy flags. It then runs `ITERS` rounds of request, grant and accept, one iteration per clock cycle. It reports, for each uplink, whether a queue was paired with it and which queue.

Each uplink has a round-robin grant pointer, and each queue has a round-robin accept pointer. A pointer moves only when a pairing made in the first iteration is later confirmed by the centre stage. This makes the arbiters of many ingress modules drift apart in phase. The confirmation comes back as one strobe with one bit per uplink, and it is taken while the result is held.

Top module: `vm_link_matcher`

## Requirements
- R1: A `start` pulse sampled while idle snapshots `voq_nonempty`. It clears all results and lowers `done`. `done` rises exactly `ITERS` clock edges after the start edge and stays high until the next accepted start.
- R2: In the first iteration, each uplink grants the first nonempty queue, searching cyclically upward from its grant pointer.
- R3: A queue that receives one or more grants accepts the first granting uplink, searching cyclically upward from its accept pointer. The uplink then reports `link_valid`=1 and `link_voq`=queue index.
- R4: In each later iteration only queues and uplinks still unpaired take part. An established pairing keeps its valid flag and index until the next start.
- R5: No two valid uplinks report the same queue. Every reported queue was flagged nonempty in the snapshot.
- R6: An uplink left unpaired after the last iteration reports `link_valid`=0. With no queue nonempty, no uplink is valid.
- R7: A `cm_ack_valid` strobe while `done`=1 moves pointers for every uplink r that has `cm_ack[r]`=1 and was paired in the first iteration. Uplink r's grant pointer becomes (queue+1) mod `NUM_VOQ`. That queue's accept pointer becomes (r+1) mod `NUM_LINK`.
- R8: No pointer moves in any of these cases: an uplink whose `cm_ack` bit is 0, a pairing made after the first iteration, a strobe while `done`=0, or a second strobe in the same round. This is visible through the pairings of the following round.
- R9: `start` while an iteration sequence is running is ignored.
- R10: After reset all pointers are 0, every `link_valid` is 0 and `done` is 0.
- R11: Both `ITERS`=1 and `ITERS`=4 are supported with the behaviour above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a matching round (ignored while running) |
| voq_nonempty | input | NUM_VOQ | Occupancy flag per queue |
| cm_ack_valid | input | 1 | Centre-stage confirmation strobe |
| cm_ack | input | NUM_LINK | Per-uplink confirmation bit |
| link_valid | output | NUM_LINK | Uplink holds a pairing |
| link_voq | output | NUM_LINK x idx_w(NUM_VOQ) | Paired queue index per uplink |
| done | output | 1 | Result of the round is final |

## Verification
The embedded properties check on every cycle the following: a pairing persists while iterations run, no queue appears twice, every reported queue was occupied in the snapshot, `done` rises after the last iteration, a start is ignored mid-sequence, and pointers hold when no confirmation applies. The round-robin order itself cannot be checked by a single property. Nor can the rule that only confirmed first-iteration pairings advance pointers. These effects show only across rounds, through the pairings chosen later. The bench's behavioural model and its directed scenarios with full, single-queue, empty and partially confirmed rounds expose them, for one-iteration and four-iteration instances side by side.

// File: rtl/vm_pkg.sv
package vm_pkg;
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vm_rr_arb.sv
module vm_rr_arb #(
  parameter int W  = 8,
  parameter int PW = vm_pkg::idx_w(W)
) (
  input  logic [W-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic [W-1:0]  gnt,
  output logic [PW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < W; i++) begin
      int p;
      p = (int'(ptr) + i) % W;
      if (!any && req[p]) begin
        any    = 1'b1;
        gnt[p] = 1'b1;
        idx    = PW'(p);
      end
    end
  end
endmodule

// File: rtl/vm_match_step.sv
module vm_match_step #(
  parameter int NV = 8,
  parameter int M  = 4,
  parameter int VW = vm_pkg::idx_w(NV),
  parameter int LW = vm_pkg::idx_w(M)
) (
  input  logic [NV-1:0]         voq_req,
  input  logic [M-1:0]          link_free,
  input  logic [M-1:0][VW-1:0]  grant_ptr,
  input  logic [NV-1:0][LW-1:0] accept_ptr,
  output logic [M-1:0]          link_new,
  output logic [M-1:0][VW-1:0]  link_new_idx,
  output logic [NV-1:0]         voq_hit
);
  logic [M-1:0][NV-1:0] gnt_by_link;
  logic [NV-1:0][M-1:0] gnt_by_voq;
  logic [NV-1:0][M-1:0] acc_by_voq;

  // grant stage: one arbiter per uplink
  for (genvar r = 0; r < M; r++) begin : g_grant
    logic [VW-1:0] unused_idx;
    logic          unused_any;
    vm_rr_arb #(.W(NV), .PW(VW)) u_garb (
      .req (voq_req & {NV{link_free[r]}}),
      .ptr (grant_ptr[r]),
      .gnt (gnt_by_link[r]),
      .idx (unused_idx),
      .any (unused_any)
    );
  end

  // accept stage: one arbiter per queue
  for (genvar v = 0; v < NV; v++) begin : g_accept
    logic [LW-1:0] unused_idx;
    for (genvar r = 0; r < M; r++) begin : g_tr
      assign gnt_by_voq[v][r] = gnt_by_link[r][v];
    end
    vm_rr_arb #(.W(M), .PW(LW)) u_aarb (
      .req (gnt_by_voq[v]),
      .ptr (accept_ptr[v]),
      .gnt (acc_by_voq[v]),
      .idx (unused_idx),
      .any (voq_hit[v])
    );
  end

  always_comb begin
    link_new     = '0;
    link_new_idx = '0;
    for (int v = 0; v < NV; v++) begin
      for (int r = 0; r < M; r++) begin
        if (acc_by_voq[v][r]) begin
          link_new[r]     = 1'b1;
          link_new_idx[r] = VW'(v);
        end
      end
    end
  end
endmodule

// File: rtl/vm_ptr_bank.sv
module vm_ptr_bank #(
  parameter int NV = 8,
  parameter int M  = 4,
  parameter int VW = vm_pkg::idx_w(NV),
  parameter int LW = vm_pkg::idx_w(M)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [M-1:0]          upd,
  input  logic [M-1:0][VW-1:0]  upd_voq,
  output logic [M-1:0][VW-1:0]  grant_ptr,
  output logic [NV-1:0][LW-1:0] accept_ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      grant_ptr  <= '0;
      accept_ptr <= '0;
    end else begin
      for (int r = 0; r < M; r++) begin
        if (upd[r]) begin
          grant_ptr[r] <= (int'(upd_voq[r]) == NV - 1) ? '0 : upd_voq[r] + 1'b1;
          accept_ptr[upd_voq[r]] <= (r == M - 1) ? '0 : LW'(r + 1);
        end
      end
    end
  end

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (upd == '0) |=> ($stable(grant_ptr) && $stable(accept_ptr)));
endmodule

// File: rtl/vm_link_matcher.sv
module vm_link_matcher
  import vm_pkg::*;
#(
  parameter int NUM_VOQ  = 8,
  parameter int NUM_LINK = 4,
  parameter int ITERS    = 4,
  localparam int VW = idx_w(NUM_VOQ),
  localparam int LW = idx_w(NUM_LINK),
  localparam int TW = idx_w(ITERS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [NUM_VOQ-1:0]           voq_nonempty,
  input  logic                         cm_ack_valid,
  input  logic [NUM_LINK-1:0]          cm_ack,
  output logic [NUM_LINK-1:0]          link_valid,
  output logic [NUM_LINK-1:0][VW-1:0]  link_voq,
  output logic                         done
);
  localparam logic [TW-1:0] LAST_IT = TW'(ITERS - 1);

  logic                         busy;
  logic [TW-1:0]                iter;
  logic [NUM_VOQ-1:0]           snap;
  logic [NUM_VOQ-1:0]           taken;
  logic [NUM_LINK-1:0]          first_it;
  logic [NUM_LINK-1:0][VW-1:0]  grant_ptr;
  logic [NUM_VOQ-1:0][LW-1:0]   accept_ptr;
  logic [NUM_LINK-1:0]          link_new;
  logic [NUM_LINK-1:0][VW-1:0]  link_new_idx;
  logic [NUM_VOQ-1:0]           voq_hit;
  logic [NUM_LINK-1:0]          ptr_upd;

  vm_match_step #(.NV(NUM_VOQ), .M(NUM_LINK), .VW(VW), .LW(LW)) u_step (
    .voq_req      (snap & ~taken),
    .link_free    (~link_valid & {NUM_LINK{busy}}),
    .grant_ptr    (grant_ptr),
    .accept_ptr   (accept_ptr),
    .link_new     (link_new),
    .link_new_idx (link_new_idx),
    .voq_hit      (voq_hit)
  );

  assign ptr_upd = {NUM_LINK{done & cm_ack_valid}} & cm_ack & first_it & link_valid;

  vm_ptr_bank #(.NV(NUM_VOQ), .M(NUM_LINK), .VW(VW), .LW(LW)) u_ptrs (
    .clk        (clk),
    .rst        (rst),
    .upd        (ptr_upd),
    .upd_voq    (link_voq),
    .grant_ptr  (grant_ptr),
    .accept_ptr (accept_ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      iter       <= '0;
      done       <= 1'b0;
      snap       <= '0;
      taken      <= '0;
      first_it   <= '0;
      link_valid <= '0;
      link_voq   <= '0;
    end else if (!busy && start) begin
      busy       <= 1'b1;
      iter       <= '0;
      done       <= 1'b0;
      snap       <= voq_nonempty;
      taken      <= '0;
      first_it   <= '0;
      link_valid <= '0;
      link_voq   <= '0;
    end else if (busy) begin
      for (int r = 0; r < NUM_LINK; r++) begin
        if (link_new[r]) begin
          link_valid[r] <= 1'b1;
          link_voq[r]   <= link_new_idx[r];
          first_it[r]   <= (iter == '0);
        end
      end
      taken <= taken | voq_hit;
      if (iter == LAST_IT) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        iter <= iter + 1'b1;
      end
    end else if (done && cm_ack_valid) begin
      first_it <= '0;
    end
  end

  // R1
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && iter == LAST_IT) |=> (done && !busy));

  // R9
  start_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && iter != LAST_IT) |=> (busy && !done));

  for (genvar r = 0; r < NUM_LINK; r++) begin : g_chk
    // R4
    link_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && link_valid[r]) |=> (link_valid[r] && $stable(link_voq[r])));
    // R5
    link_src_chk: assert property (@(posedge clk) disable iff (rst)
      link_valid[r] |-> snap[link_voq[r]]);
    for (genvar s = r + 1; s < NUM_LINK; s++) begin : g_pair
      // R5
      voq_once_chk: assert property (@(posedge clk) disable iff (rst)
        (link_valid[r] && link_valid[s]) |-> (link_voq[r] != link_voq[s]));
    end
  end
endmodule

// File: tb/test_vm_link_matcher.sv
module vm_harness #(
  parameter int NV = 8,
  parameter int M  = 4,
  parameter int IT = 4,
  localparam int VW = vm_pkg::idx_w(NV)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [NV-1:0]        ne,
  input  logic                 ackv,
  input  logic [M-1:0]         ack,
  output logic [M-1:0]         lv,
  output logic [M-1:0][VW-1:0] lq,
  output logic                 dn,
  output int                   checks,
  output int                   fails
);
  vm_link_matcher #(.NUM_VOQ(NV), .NUM_LINK(M), .ITERS(IT)) i_vm_link_matcher (
    .clk(clk), .rst(rst), .start(start), .voq_nonempty(ne),
    .cm_ack_valid(ackv), .cm_ack(ack),
    .link_valid(lv), .link_voq(lq), .done(dn));

  int  lp[M], vp[NV], mq[M], gsel[M];
  bit  mv[M], fst[M], snap[NV], tkn[NV];
  bit  busy, mdone, seen;
  int  it;

  initial begin checks = 0; fails = 0; seen = 0; end

  always @(posedge clk) begin
    if (rst) begin
      foreach (lp[r]) begin lp[r] = 0; mv[r] = 0; fst[r] = 0; mq[r] = 0; end
      foreach (vp[v]) begin vp[v] = 0; snap[v] = 0; tkn[v] = 0; end
      busy = 0; mdone = 0; it = 0; seen = 1;
    end else begin
      if (mdone && ackv) begin
        for (int r = 0; r < M; r++)
          if (ack[r] && fst[r] && mv[r]) begin
            lp[r] = (mq[r] + 1) % NV;
            vp[mq[r]] = (r + 1) % M;
          end
        if (!busy && !start) foreach (fst[r]) fst[r] = 0;
      end
      if (!busy && start) begin
        busy = 1; it = 0; mdone = 0;
        foreach (snap[v]) begin snap[v] = ne[v]; tkn[v] = 0; end
        foreach (mv[r]) begin mv[r] = 0; mq[r] = 0; fst[r] = 0; end
      end else if (busy) begin
        for (int r = 0; r < M; r++) begin
          gsel[r] = -1;
          if (!mv[r])
            for (int i = 0; i < NV; i++) begin
              int v;
              v = (lp[r] + i) % NV;
              if (gsel[r] < 0 && snap[v] && !tkn[v]) gsel[r] = v;
            end
        end
        for (int v = 0; v < NV; v++) begin
          int pick;
          pick = -1;
          for (int i = 0; i < M; i++) begin
            int r;
            r = (vp[v] + i) % M;
            if (pick < 0 && gsel[r] == v) pick = r;
          end
          if (pick >= 0) begin
            mv[pick] = 1; mq[pick] = v; fst[pick] = (it == 0); tkn[v] = 1;
          end
        end
        if (it == IT - 1) begin busy = 0; mdone = 1; end else it++;
      end
    end
  end

  always @(negedge clk) begin
    if (seen) begin
      checks++;
      if (dn !== mdone) begin
        fails++;
        $display("FAIL R1 R9 R10 IT=%0d done actual=%b expected=%b", IT, dn, mdone);
      end
      for (int r = 0; r < M; r++) begin
        checks++;
        if (lv[r] !== mv[r] || (mv[r] && int'(lq[r]) != mq[r])) begin
          fails++;
          $display("FAIL R2 R3 R4 R6 R7 R8 IT=%0d link%0d actual=%b/%0d expected=%b/%0d",
                   IT, r, lv[r], lq[r], mv[r], mq[r]);
        end
        for (int s = r + 1; s < M; s++) begin
          checks++;
          if (lv[r] && lv[s] && lq[r] == lq[s]) begin
            fails++;
            $display("FAIL R5 IT=%0d links %0d,%0d share queue actual=%0d expected=distinct",
                     IT, r, s, lq[r]);
          end
        end
      end
    end
  end
endmodule

module test_vm_link_matcher;
  localparam int NV = 8, M = 4, VW = 3;
  logic clk = 0, rst = 1, start = 0, ackv = 0;
  logic [NV-1:0] ne = '0;
  logic [M-1:0]  ack = '0;
  logic [M-1:0] lv4, lv1;
  logic [M-1:0][VW-1:0] lq4, lq1;
  logic dn4, dn1;
  int c4, f4, c1, f1, checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  // R11: four-iteration and one-iteration instances
  vm_harness #(.NV(NV), .M(M), .IT(4)) h4 (.clk(clk), .rst(rst), .start(start), .ne(ne),
    .ackv(ackv), .ack(ack), .lv(lv4), .lq(lq4), .dn(dn4), .checks(c4), .fails(f4));
  vm_harness #(.NV(NV), .M(M), .IT(1)) h1 (.clk(clk), .rst(rst), .start(start), .ne(ne),
    .ackv(ackv), .ack(ack), .lv(lv1), .lq(lq1), .dn(dn1), .checks(c1), .fails(f1));

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks + c4 + c1, fails + f4 + f1);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic round(input logic [NV-1:0] pat);
    start = 1; ne = pat; cycles(1);
    start = 0; cycles(4);
  endtask

  task automatic confirm(input logic [M-1:0] bits);
    ackv = 1; ack = bits; cycles(1);
    ackv = 0; ack = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    cycles(3);
    rst = 0;
    cycles(1);
    chk("R10 valid after reset", 32'(lv4), 0);
    chk("R10 done after reset", 32'(dn4), 0);
    // R1 R2 R3 R4: all queues full, pointers at zero
    round('1);
    chk("R1 done", 32'(dn4), 1);
    chk("R4 valid ITERS4", 32'(lv4), 32'hf);
    chk("R2 R3 link voqs ITERS4", 32'(lq4), {20'h0, 3'd3, 3'd2, 3'd1, 3'd0});
    chk("R11 valid ITERS1", 32'(lv1), 32'h1);
    chk("R6 unpaired low ITERS1", 32'(lv1[3:1]), 0);
    // R7: only link0 paired in first iteration moves pointers
    confirm('1);
    round('1);
    chk("R7 link voqs ITERS4", 32'(lq4), {20'h0, 3'd3, 3'd2, 3'd0, 3'd1});
    chk("R7 valid ITERS1", 32'(lv1), 32'h3);
    // R8: strobe with bits clear, then no change next round
    confirm('0);
    round('1);
    chk("R8 unchanged ITERS4", 32'(lq4), {20'h0, 3'd3, 3'd2, 3'd0, 3'd1});
    // R9: start during the run is ignored
    start = 1; ne = 8'h20; cycles(1);
    start = 1; ne = 8'h01; cycles(2);
    start = 0; cycles(3);
    chk("R9 single queue kept", 32'(lv4 != 0 && lq4[0] == 3'd5 || lv4[1] && lq4[1] == 3'd5 ||
        lv4[2] && lq4[2] == 3'd5 || lv4[3] && lq4[3] == 3'd5), 1);
    chk("R6 one link valid", $countones(lv4), 1);
    // R8: strobe while busy, then double strobe
    start = 1; ne = 8'hff; cycles(1);
    start = 0; ackv = 1; ack = '1; cycles(1);
    ackv = 0; ack = '0; cycles(3);
    confirm(4'h5);
    confirm(4'hf);
    // R6: empty round
    round('0);
    chk("R6 none valid ITERS4", 32'(lv4), 0);
    chk("R6 none valid ITERS1", 32'(lv1), 0);
    // R2 R3 R5 R7 R8: random traffic against the model
    for (int k = 0; k < 300; k++) begin
      round(NV'($urandom));
      if ($urandom % 4 != 0) confirm(M'($urandom));
      if ($urandom % 3 == 0) cycles(1);
    end
    finish_run();
  end
endmodule